// File: doc/BRIEF.md
# Floppy Read Data Register

This block turns the serial read pulses from a floppy drive into bytes. The bytes go to a host through one 8-bit register, and the top bit of that register marks a complete byte. All timing runs from one fast clock. A mode bit selects either the full clock rate or half of it for bit-cell timing. The bus clock plays no part in the read path. A bit cell that contains a pulse records a 1, and a full cell with no pulse records a 0. The cell timer restarts on every pulse so that it stays locked to the incoming stream.

Three mode bits set how the register behaves toward the host. The host loads them through a separate write strobe, which stands for a bus write made with both control switches asserted.
- **Synchronous mode:** the register shows each byte as soon as it completes.
- **Latched asynchronous mode:** a byte is held until the host has read it, and then the register clears when the select line is released.
- **Port operation:** asynchronous mode with the latch bit off and select held low. The register behaves as if the host were reading without pause. Each byte is cleared after a fixed display time, and the top bit is guaranteed a minimum low time before it rises again. External registers can therefore use the top bit as a clock.

Top module: `fdr_top`

## Requirements
- R1: While `rst` is high, and after it falls, `data_out`, the shift register and the mode bits are all 0.
- R2: A cycle with `mode_we` high loads the mode bits from `mode_din`: bit 2 selects the fast clock rate (1) or half rate (0), bit 1 selects asynchronous mode, and bit 0 selects latch mode.
- R3: A `rd_pulse` sampled high shifts in a 1 and restarts the cell window. A window of CELL_TICKS timing ticks with no pulse shifts in a 0 and restarts the window. If a pulse and an expiry fall on the same edge, the pulse wins.
- R4: Bits enter MSB-first. A byte is complete when a 1 reaches bit 7, and the shift register then restarts from zero. In synchronous mode the completed byte appears on `data_out` after the rising edge that follows the edge that sampled its final bit.
- R5: In synchronous mode (mode bit 1 = 0), every completed byte is loaded into `data_out`, and `dev_n` has no effect on it.
- R6: With mode bit 2 = 0, a timing tick occurs on every second clock, and the tick phase restarts on each pulse, so one bit cell lasts 2*CELL_TICKS clocks.
- R7: In latched mode (mode bits 1 and 0 = 1), a byte is loaded only into a register whose MSB is 0. The register clears to 0 at the first rising edge that samples `dev_n` high after an edge that sampled `dev_n` low with the MSB set.
- R8: In latched mode, a byte that completes while an unread byte with its MSB set is held is discarded, and `data_out` keeps the unread byte.
- R9: In port operation (mode bit 1 = 1, mode bit 0 = 0), a register with its MSB set clears to 0 after PORT_HOLD consecutive clocks with `dev_n` low.
- R10: In port operation, the MSB of `data_out` stays low for at least MSB_LOW_MIN clocks before it is set again. A byte that completes too early waits in a one-entry slot and is shown once the low time has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Mode write strobe, one cycle |
| mode_din | input | 3 | Mode word: [2] fast rate, [1] asynchronous, [0] latch |
| rd_pulse | input | 1 | Read pulse from the drive, already synchronous to `clk` |
| dev_n | input | 1 | Device select, active low; a low phase is a host read |
| data_out | output | BYTE_W | Read data register; the MSB marks a complete byte |

## Verification
The bench goes after the cases where the read register's lifetime matters:
- **Unread byte in latched mode:** a byte arrives while an unread one is held. A design that overwrites would show the newer byte instead of keeping the old one.
- **Latched clear on select:** the clear must happen exactly on the release of select after a read. A design that clears on any select edge, or never, leaves the wrong value in place.
- **Slow rate:** half-rate bytes are sent with doubled cells. A design that ignores the rate bit shifts in extra zeros and builds a different byte.
- **Port-operation spacing:** bytes are fed back to back so that the next byte is ready before the low time has passed. A design without the guard raises the MSB after one or two low clocks, and a design that loses the waiting byte never raises it again.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    // Mode word as written by the host: bit 2 fast, bit 1 async, bit 0 latch
    typedef struct packed {
        logic fast;
        logic async_en;
        logic latch_en;
    } fdr_mode_t;

    // How the output register treats completed bytes and host reads
    typedef enum logic [1:0] {
        POL_SYNC  = 2'd0,
        POL_LATCH = 2'd1,
        POL_PORT  = 2'd2
    } fdr_policy_t;

    function automatic fdr_policy_t policy_of(input fdr_mode_t m);
        if (!m.async_en)
            return POL_SYNC;
        else if (m.latch_en)
            return POL_LATCH;
        else
            return POL_PORT;
    endfunction

endpackage

// File: rtl/fdr_tick_gen.sv
module fdr_tick_gen (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    input  logic resync,
    output logic tick
);
    logic phase_q;

    // Half-rate phase restarts on every pulse so the cell timing is deterministic
    always_ff @(posedge clk) begin
        if (rst || resync)
            phase_q <= 1'b0;
        else
            phase_q <= ~phase_q;
    end

    assign tick = fast | phase_q;

endmodule

// File: rtl/fdr_deser.sv
module fdr_deser #(
    parameter int unsigned CELL_TICKS = 4,
    parameter int unsigned BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rd_pulse,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int unsigned CW = (CELL_TICKS > 1) ? $clog2(CELL_TICKS) : 1;
    localparam logic [CW-1:0] CELL_LAST = CW'(CELL_TICKS - 1);

    logic [CW-1:0]     cell_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nxt;
    logic              expire;
    logic              bit_en;

    assign expire    = tick && (cell_cnt == CELL_LAST);
    assign bit_en    = rd_pulse || expire;
    assign shreg_nxt = {shreg[BYTE_W-2:0], rd_pulse};

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_cnt <= '0;
            shreg    <= '0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (rd_pulse || expire)
                cell_cnt <= '0;
            else if (tick)
                cell_cnt <= cell_cnt + 1'b1;

            if (bit_en) begin
                if (shreg_nxt[BYTE_W-1]) begin
                    byte_q   <= shreg_nxt;
                    byte_vld <= 1'b1;
                    shreg    <= '0;
                end else begin
                    shreg <= shreg_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/fdr_out_reg.sv
module fdr_out_reg
    import fdr_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned MSB_LOW_MIN = 6,
    parameter int unsigned PORT_HOLD   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  fdr_policy_t       policy,
    input  logic              dev_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_q,
    output logic [BYTE_W-1:0] data_out
);
    localparam int unsigned LW = $clog2(MSB_LOW_MIN + 1);
    localparam int unsigned HW = (PORT_HOLD > 1) ? $clog2(PORT_HOLD) : 1;
    localparam logic [LW-1:0] LOW_SAT   = LW'(MSB_LOW_MIN);
    localparam logic [LW-1:0] GAP_REQ   = LW'(MSB_LOW_MIN - 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(PORT_HOLD - 1);

    logic [BYTE_W-1:0] dreg;
    logic [BYTE_W-1:0] pend_q;
    logic              pend_vld;
    logic [LW-1:0]     low_cnt;
    logic [HW-1:0]     hold_cnt;
    logic              read_seen;

    logic              msb;
    logic              have;
    logic [BYTE_W-1:0] src;
    logic              ld;
    logic              clr;

    assign msb  = dreg[BYTE_W-1];
    assign have = byte_vld || pend_vld;
    assign src  = byte_vld ? byte_q : pend_q;

    always_comb begin
        ld  = 1'b0;
        clr = 1'b0;
        unique case (policy)
            POL_SYNC: begin
                ld = byte_vld;
            end
            POL_LATCH: begin
                ld  = have && !msb;
                clr = msb && dev_n && read_seen;
            end
            POL_PORT: begin
                ld  = have && !msb && (low_cnt >= GAP_REQ);
                clr = msb && !dev_n && (hold_cnt == HOLD_LAST);
            end
            default: begin
                ld  = 1'b0;
                clr = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dreg      <= '0;
            pend_q    <= '0;
            pend_vld  <= 1'b0;
            low_cnt   <= '0;
            hold_cnt  <= '0;
            read_seen <= 1'b0;
        end else begin
            if (ld)
                dreg <= src;
            else if (clr)
                dreg <= '0;

            // One waiting byte, only while the low-time guard is active
            if (policy == POL_PORT && have && !ld) begin
                pend_vld <= 1'b1;
                pend_q   <= src;
            end else begin
                pend_vld <= 1'b0;
            end

            if (msb)
                low_cnt <= '0;
            else if (low_cnt != LOW_SAT)
                low_cnt <= low_cnt + 1'b1;

            if (ld || clr || !msb || dev_n)
                hold_cnt <= '0;
            else
                hold_cnt <= hold_cnt + 1'b1;

            if (ld || clr)
                read_seen <= 1'b0;
            else if (msb && !dev_n)
                read_seen <= 1'b1;
        end
    end

    assign data_out = dreg;

endmodule

// File: rtl/fdr_top.sv
module fdr_top
    import fdr_pkg::*;
#(
    parameter int unsigned CELL_TICKS  = 4,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned MSB_LOW_MIN = 6,
    parameter int unsigned PORT_HOLD   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [2:0]        mode_din,
    input  logic              rd_pulse,
    input  logic              dev_n,
    output logic [BYTE_W-1:0] data_out
);
    fdr_mode_t         mode_q;
    fdr_policy_t       policy_w;
    logic              tick_w;
    logic              byte_vld_w;
    logic [BYTE_W-1:0] byte_w;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (mode_we)
            mode_q <= fdr_mode_t'(mode_din);
    end

    assign policy_w = policy_of(mode_q);

    fdr_tick_gen tick_i (
        .clk    (clk),
        .rst    (rst),
        .fast   (mode_q.fast),
        .resync (rd_pulse),
        .tick   (tick_w)
    );

    fdr_deser #(
        .CELL_TICKS (CELL_TICKS),
        .BYTE_W     (BYTE_W)
    ) deser_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_w),
        .rd_pulse (rd_pulse),
        .byte_vld (byte_vld_w),
        .byte_q   (byte_w)
    );

    fdr_out_reg #(
        .BYTE_W      (BYTE_W),
        .MSB_LOW_MIN (MSB_LOW_MIN),
        .PORT_HOLD   (PORT_HOLD)
    ) oreg_i (
        .clk      (clk),
        .rst      (rst),
        .policy   (policy_w),
        .dev_n    (dev_n),
        .byte_vld (byte_vld_w),
        .byte_q   (byte_w),
        .data_out (data_out)
    );

endmodule

// File: rtl/fdr_checker.sv
module fdr_checker
    import fdr_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned MSB_LOW_MIN = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_n,
    input logic [BYTE_W-1:0] data_out,
    input fdr_policy_t       policy,
    input logic              byte_vld
);
    localparam int unsigned LW = $clog2(MSB_LOW_MIN + 1);
    localparam logic [LW-1:0] RUN_SAT = LW'(MSB_LOW_MIN);

    logic [LW-1:0] lowrun;

    always_ff @(posedge clk) begin
        if (rst)
            lowrun <= '0;
        else if (data_out[BYTE_W-1])
            lowrun <= '0;
        else if (lowrun != RUN_SAT)
            lowrun <= lowrun + 1'b1;
    end

    AST_RST_ZERO: assert property (@(posedge clk)
        rst |=> (data_out == '0)); // R1

    AST_SYNC_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
        (policy == POL_SYNC && $past(policy) == POL_SYNC && !$past(byte_vld))
        |-> $stable(data_out)); // R5

    AST_LATCH_CLR_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (policy == POL_LATCH && $past(policy) == POL_LATCH &&
         $past(data_out[BYTE_W-1]) && data_out == '0)
        |-> $past(dev_n)); // R7

    AST_LATCH_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (policy == POL_LATCH && $past(policy) == POL_LATCH &&
         $past(data_out[BYTE_W-1]) && data_out != $past(data_out))
        |-> (data_out == '0)); // R8

    AST_MSB_LOW_GAP: assert property (@(posedge clk) disable iff (rst)
        (policy == POL_PORT && $past(policy) == POL_PORT && $rose(data_out[BYTE_W-1]))
        |-> (lowrun >= RUN_SAT)); // R10

endmodule

bind fdr_top fdr_checker #(
    .BYTE_W      (BYTE_W),
    .MSB_LOW_MIN (MSB_LOW_MIN)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .dev_n    (dev_n),
    .data_out (data_out),
    .policy   (policy_w),
    .byte_vld (byte_vld_w)
);

// File: tb/fdr_top_tb_top.sv
`timescale 1ns/1ps
module fdr_top_tb_top;

    localparam int CELL = 4;
    localparam int LOWMIN = 6;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [2:0] mode_din = 3'b000;
    logic       rd_pulse = 1'b0;
    logic       dev_n = 1'b1;
    logic [7:0] data_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fdr_top #(
        .CELL_TICKS  (CELL),
        .BYTE_W      (8),
        .MSB_LOW_MIN (LOWMIN),
        .PORT_HOLD   (HOLD)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .mode_we  (mode_we),
        .mode_din (mode_din),
        .rd_pulse (rd_pulse),
        .dev_n    (dev_n),
        .data_out (data_out)
    );

    // {pulse pattern, expected register} in fast synchronous mode
    localparam logic [15:0] VEC [8] = '{
        16'hD5D5, 16'hAAAA, 16'h9696, 16'hFFFF,
        16'h8080, 16'hE7E7, 16'hB9B9, 16'hCBCB
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [2:0] m);
        mode_din = m;
        mode_we  = 1'b1;
        @(negedge clk);
        mode_we  = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int slot);
        for (int i = 7; i >= 0; i--) begin
            rd_pulse = b[i];
            @(negedge clk);
            rd_pulse = 1'b0;
            repeat (slot - 1) @(negedge clk);
        end
    endtask

    task automatic host_read();
        dev_n = 1'b0;
        repeat (2) @(negedge clk);
        dev_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int     phase;
        int     lowrun;
        int     gap_seen;
        logic [7:0] second;

        repeat (3) @(negedge clk);
        check("R1 during reset", data_out, 8'h00);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 after reset", data_out, 8'h00);

        // R2 R3 R4 R5: fast synchronous vectors
        wr_mode(3'b100);
        for (int v = 0; v < 8; v++) begin
            send_byte(VEC[v][15:8], CELL);
            check("R4 sync byte (R3 cells)", data_out, VEC[v][7:0]);
        end

        host_read();
        repeat (2) @(negedge clk);
        check("R5 select ignored in sync", data_out, 8'hCB);

        // R6: half rate, doubled cells
        wr_mode(3'b000);
        send_byte(8'hC9, 2 * CELL);
        check("R6 slow byte", data_out, 8'hC9);

        // R7 R8: latched asynchronous mode
        wr_mode(3'b111);
        host_read();
        check("R7 clear on deselect", data_out, 8'h00);
        send_byte(8'hD5, CELL);
        check("R7 latched load", data_out, 8'hD5);
        send_byte(8'hAA, CELL);
        check("R8 unread byte kept", data_out, 8'hD5);
        host_read();
        check("R7 clear after read", data_out, 8'h00);
        send_byte(8'h96, CELL);
        check("R7 reload after clear", data_out, 8'h96);

        // R9 R10: port operation, select held low
        wr_mode(3'b110);
        dev_n = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 held byte cleared", data_out, 8'h00);
        send_byte(8'hFF, CELL);
        check("R9 byte shown", data_out, 8'hFF);
        repeat (HOLD) @(negedge clk);
        check("R9 cleared after hold", data_out, 8'h00);

        phase = 0;
        lowrun = 0;
        gap_seen = 0;
        second = 8'h00;
        for (int i = 0; i < 70; i++) begin
            rd_pulse = (i < 16);
            @(negedge clk);
            case (phase)
                0: if (data_out[7]) phase = 1;
                1: if (!data_out[7]) begin phase = 2; lowrun = 1; end
                2: if (data_out[7]) begin
                       phase = 3;
                       gap_seen = lowrun;
                       second = data_out;
                   end else lowrun++;
                default: ;
            endcase
        end
        rd_pulse = 1'b0;
        n_chk++;
        if (phase != 3 || gap_seen < LOWMIN) begin
            n_err++;
            $display("FAIL R10 low gap actual=%0d expected>=%0d", gap_seen, LOWMIN);
        end
        check("R10 waiting byte shown (R4)", second, 8'hFF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule